// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of a byte-wide parallel NOR flash. It takes one request at a time and turns it into the unlock and command write cycles the device expects. A request names an operation (program one byte, erase one sector, erase the whole chip, or read an identification byte), an address and a data byte. The block drives the chip enable, write enable and output enable strobes with setup, pulse and hold lengths counted in clocks. It then reads status from the device until the embedded operation is over, and returns a done pulse with a result code.

Completion is found in two ways. Bit 7 of a status read can show the true value that is expected: bit 7 of the payload for a program, 1 for an erase. Bit 6 can also read the same in two reads in a row, which means it has stopped toggling. Bit 5 set while the device is still busy triggers one confirming read. If that read still shows the device busy, the operation is reported as a device timeout. A clock-free poll counter gives up after a fixed number of reads. In both failure cases the block writes the reset command before it reports back. The identification read enters the ID mode, reads one byte and leaves the mode with the same reset command.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, reqReady is 1, doneValid is 0, and flashCeN, flashWeN and flashOeN are all 1.
- R2: Operation code 0 (program) writes, in this order, AAh to 555h, 55h to 2AAh, A0h to 555h, and then reqData to reqAddr. Any address may be programmed in any order.
- R3: Operation code 1 (sector erase) writes AAh to 555h, 55h to 2AAh, 80h to 555h, AAh to 555h, 55h to 2AAh, and then 30h to reqAddr.
- R4: Operation code 2 (chip erase) writes the same first five cycles as R3, and then 10h to 555h.
- R5: In every write cycle, chip enable is low for T_SETUP clocks before write enable falls. Write enable stays low for T_PULSE clocks. Chip enable stays low for T_HOLD clocks after write enable rises. Address and data are stable while write enable is low. Output enable and write enable are never low together.
- R6: After the command writes, status is read at reqAddr. The operation ends with status 0 on the first read whose bit 7 equals the expected bit: reqData bit 7 for a program, 1 for an erase.
- R7: A status read whose bit 6 equals bit 6 of the previous status read of the same operation also ends the operation with status 0.
- R8: A status read that does not complete and has bit 5 set is followed by exactly one more read. If that read completes, the result is status 0. Otherwise the block writes F0h to 555h and reports status 1.
- R9: If WD_LIMIT status reads all fail to complete, the block writes F0h to 555h and reports status 2, having made exactly WD_LIMIT reads.
- R10: Operation code 3 (read ID) writes AAh to 555h, 55h to 2AAh and 90h to 555h. It then reads once at reqAddr, places that byte on idData, writes F0h to 555h and reports status 0.
- R11: reqReady is 0 from the cycle after a request is accepted until the operation ends. reqValid has no effect while reqReady is 0.
- R12: doneValid is a single-cycle pulse. doneStatus is 0 for success, 1 for a device timeout and 2 for a watchdog expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when reqReady is 1 |
| reqOp | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 read ID |
| reqAddr | input | ADDR_W | Target byte or sector address |
| reqData | input | 8 | Byte to program |
| reqReady | output | 1 | Idle, will take a request |
| doneValid | output | 1 | One-cycle completion pulse |
| doneStatus | output | 2 | Result code, valid with doneValid |
| idData | output | 8 | Byte read by the last read-ID request |
| flashAddr | output | ADDR_W | Flash address bus |
| flashDqOut | output | 8 | Data driven to the flash |
| flashDqOe | output | 1 | Data bus drive enable |
| flashDqIn | input | 8 | Data read from the flash |
| flashCeN | output | 1 | Chip enable, active low |
| flashWeN | output | 1 | Write enable, active low |
| flashOeN | output | 1 | Output enable, active low |

## Verification
Program requests are swept over a grid of addresses (low, high, both unlock addresses, an arbitrary one), payloads (bit 7 clear or set, all zeros, all ones) and busy lengths. This shows that the expected-bit-7 rule follows the payload and not a fixed value. Erase requests use the fixed expectation of 1 instead. Separate device behaviours are played back to tell the completion paths apart: bit 7 settling, bit 6 freezing while bit 7 stays wrong, bit 5 followed by recovery or by continued busy, and a device that never finishes. The read count and the trailing reset write tell each outcome apart. Requests raised while busy must leave the write log and the next operation unchanged.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_ID   = 2'd3
  } op_t;

  typedef enum logic [1:0] {
    AS_UNLOCK1 = 2'd0,
    AS_UNLOCK2 = 2'd1,
    AS_TARGET  = 2'd2
  } addr_sel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      start;
    logic      isWrite;
    addr_sel_t addrSel;
    logic      usePayload;
    logic [7:0] cmdByte;
    logic      latchReq;
  } bus_cmd_t;

  typedef struct packed {
    addr_sel_t  a;
    logic       p;
    logic [7:0] c;
    logic       last;
  } step_t;

  localparam logic [1:0] ST_OK      = 2'd0;
  localparam logic [1:0] ST_DEVFAIL = 2'd1;
  localparam logic [1:0] ST_WDOG    = 2'd2;

  // command-write step table, indexed by position in the sequence
  function automatic step_t seqStep(op_t op, logic [2:0] idx);
    step_t s;
    s = '{a: AS_UNLOCK1, p: 1'b0, c: 8'hAA, last: 1'b0};
    case (idx)
      3'd0: ;
      3'd1: begin s.a = AS_UNLOCK2; s.c = 8'h55; end
      3'd2: begin
        s.c    = (op == OP_PROG) ? 8'hA0 : (op == OP_ID) ? 8'h90 : 8'h80;
        s.last = (op == OP_ID);
      end
      3'd3: if (op == OP_PROG) begin
        s.a = AS_TARGET; s.p = 1'b1; s.c = 8'h00; s.last = 1'b1;
      end
      3'd4: begin s.a = AS_UNLOCK2; s.c = 8'h55; end
      default: begin
        if (op == OP_CHIP) s.c = 8'h10;
        else begin s.a = AS_TARGET; s.c = 8'h30; end
        s.last = 1'b1;
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int T_SETUP = 1,
  parameter int T_PULSE = 3,
  parameter int T_HOLD  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  bus_cmd_t          cmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  output logic              busIdle,
  output logic              busDone,
  output logic [7:0]        rdData,
  output logic              payloadBit7,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [7:0]        flashDqOut,
  output logic              flashDqOe,
  input  logic [7:0]        flashDqIn,
  output logic              flashCeN,
  output logic              flashWeN,
  output logic              flashOeN
);

  localparam int MAX_T = (T_SETUP > T_PULSE) ? ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD)
                                             : ((T_PULSE > T_HOLD) ? T_PULSE : T_HOLD);
  localparam int CW = $clog2(MAX_T + 1) + 1;
  localparam logic [ADDR_W-1:0] ADDR_U1 = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] ADDR_U2 = ADDR_W'(12'h2AA);

  typedef enum logic [2:0] {P_IDLE, P_SETUP, P_ACT, P_HOLD, P_GAP} phase_t;

  phase_t            phase;
  logic [CW-1:0]     cnt;
  logic              isWr;
  logic [ADDR_W-1:0] busAddr;
  logic [ADDR_W-1:0] tgtAddr;
  logic [7:0]        payload;
  logic [7:0]        dOut;
  logic [ADDR_W-1:0] nextAddr;

  always_comb begin
    case (cmd.addrSel)
      AS_UNLOCK1: nextAddr = ADDR_U1;
      AS_UNLOCK2: nextAddr = ADDR_U2;
      default:    nextAddr = tgtAddr;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= P_IDLE;
      cnt     <= '0;
      isWr    <= 1'b0;
      busAddr <= '0;
      tgtAddr <= '0;
      payload <= '0;
      dOut    <= '0;
      rdData  <= '0;
    end else begin
      if (cmd.latchReq) begin
        tgtAddr <= reqAddr;
        payload <= reqData;
      end
      case (phase)
        P_IDLE: if (cmd.start) begin
          phase   <= P_SETUP;
          cnt     <= CW'(T_SETUP - 1);
          isWr    <= cmd.isWrite;
          busAddr <= nextAddr;
          dOut    <= cmd.usePayload ? payload : cmd.cmdByte;
        end
        P_SETUP: if (cnt == '0) begin
          phase <= P_ACT;
          cnt   <= CW'(T_PULSE - 1);
        end else cnt <= cnt - 1'b1;
        P_ACT: if (cnt == '0) begin
          phase <= P_HOLD;
          cnt   <= CW'(T_HOLD - 1);
          if (!isWr) rdData <= flashDqIn;
        end else cnt <= cnt - 1'b1;
        P_HOLD: if (cnt == '0) phase <= P_GAP;
                else cnt <= cnt - 1'b1;
        default: phase <= P_IDLE;
      endcase
    end
  end

  assign busIdle     = (phase == P_IDLE);
  assign busDone     = (phase == P_GAP);
  assign payloadBit7 = payload[7];
  assign flashAddr   = busAddr;
  assign flashDqOut  = dOut;
  assign flashCeN    = (phase == P_IDLE) || (phase == P_GAP);
  assign flashWeN    = !((phase == P_ACT) && isWr);
  assign flashOeN    = !((phase == P_ACT) && !isWr);
  assign flashDqOe   = isWr && (phase inside {P_SETUP, P_ACT, P_HOLD});

  assert_no_strobe_overlap_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(!flashWeN && !flashOeN));
  assert_we_inside_ce_R5: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |-> !flashCeN);
  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!flashWeN && $past(!flashWeN)) |-> ($stable(flashAddr) && $stable(flashDqOut)));
  assert_start_when_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.start |-> busIdle);

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int WD_LIMIT = 100000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  output logic       reqReady,
  output logic       doneValid,
  output logic [1:0] doneStatus,
  output logic [7:0] idData,
  output bus_cmd_t   cmd,
  input  logic       busIdle,
  input  logic       busDone,
  input  logic [7:0] rdData,
  input  logic       payloadBit7
);

  localparam int PW = $clog2(WD_LIMIT + 1);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_WRW, S_RD, S_RDW, S_RST, S_RSTW, S_DONE} state_t;

  state_t        state;
  op_t           op;
  logic [2:0]    stepIdx;
  logic          havePrev;
  logic          prevDq6;
  logic          dq5Seen;
  logic [PW-1:0] pollCnt;
  logic [1:0]    status;
  logic [7:0]    idReg;
  step_t         step;
  logic          expBit;
  logic          complete;

  assign step     = seqStep(op, stepIdx);
  assign expBit   = (op == OP_PROG) ? payloadBit7 : 1'b1;
  assign complete = (rdData[7] == expBit) || (havePrev && (rdData[6] == prevDq6));

  always_comb begin
    cmd = '0;
    case (state)
      S_IDLE: cmd.latchReq = reqValid;
      S_WR: begin
        cmd.start      = 1'b1;
        cmd.isWrite    = 1'b1;
        cmd.addrSel    = step.a;
        cmd.usePayload = step.p;
        cmd.cmdByte    = step.c;
      end
      S_RD: begin
        cmd.start   = 1'b1;
        cmd.addrSel = AS_TARGET;
      end
      S_RST: begin
        cmd.start   = 1'b1;
        cmd.isWrite = 1'b1;
        cmd.addrSel = AS_UNLOCK1;
        cmd.cmdByte = 8'hF0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      op       <= OP_PROG;
      stepIdx  <= '0;
      havePrev <= 1'b0;
      prevDq6  <= 1'b0;
      dq5Seen  <= 1'b0;
      pollCnt  <= '0;
      status   <= ST_OK;
      idReg    <= '0;
    end else begin
      case (state)
        S_IDLE: if (reqValid) begin
          op       <= op_t'(reqOp);
          stepIdx  <= '0;
          havePrev <= 1'b0;
          dq5Seen  <= 1'b0;
          pollCnt  <= '0;
          state    <= S_WR;
        end
        S_WR:  state <= S_WRW;
        S_WRW: if (busDone) begin
          if (step.last) state <= S_RD;
          else begin
            stepIdx <= stepIdx + 1'b1;
            state   <= S_WR;
          end
        end
        S_RD:  state <= S_RDW;
        S_RDW: if (busDone) begin
          if (op == OP_ID) begin
            idReg  <= rdData;
            status <= ST_OK;
            state  <= S_RST;
          end else if (complete) begin
            status <= ST_OK;
            state  <= S_DONE;
          end else if (dq5Seen) begin
            status <= ST_DEVFAIL;
            state  <= S_RST;
          end else if (pollCnt == PW'(WD_LIMIT - 1)) begin
            status <= ST_WDOG;
            state  <= S_RST;
          end else begin
            dq5Seen  <= rdData[5];
            havePrev <= 1'b1;
            prevDq6  <= rdData[6];
            pollCnt  <= pollCnt + 1'b1;
            state    <= S_RD;
          end
        end
        S_RST:  state <= S_RSTW;
        S_RSTW: if (busDone) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign reqReady   = (state == S_IDLE);
  assign doneValid  = (state == S_DONE);
  assign doneStatus = status;
  assign idData     = idReg;

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  assert_status_legal_R12: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (doneStatus != 2'd3));
  assert_accept_drops_ready_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> !reqReady);
  assert_poll_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < PW'(WD_LIMIT));
  assert_issue_on_idle_bus_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state inside {S_WR, S_RD, S_RST}) |-> busIdle);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int T_SETUP  = 1,
  parameter int T_PULSE  = 3,
  parameter int T_HOLD   = 1,
  parameter int WD_LIMIT = 100000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  output logic              reqReady,
  output logic              doneValid,
  output logic [1:0]        doneStatus,
  output logic [7:0]        idData,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [7:0]        flashDqOut,
  output logic              flashDqOe,
  input  logic [7:0]        flashDqIn,
  output logic              flashCeN,
  output logic              flashWeN,
  output logic              flashOeN
);

  bus_cmd_t   cmd;
  logic       busIdle;
  logic       busDone;
  logic [7:0] rdData;
  logic       payloadBit7;

  flash_seq_ctrl #(.WD_LIMIT(WD_LIMIT)) ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqReady(reqReady), .doneValid(doneValid), .doneStatus(doneStatus),
    .idData(idData), .cmd(cmd), .busIdle(busIdle), .busDone(busDone),
    .rdData(rdData), .payloadBit7(payloadBit7)
  );

  flash_seq_dp #(.ADDR_W(ADDR_W), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD)) dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .reqAddr(reqAddr), .reqData(reqData),
    .busIdle(busIdle), .busDone(busDone), .rdData(rdData), .payloadBit7(payloadBit7),
    .flashAddr(flashAddr), .flashDqOut(flashDqOut), .flashDqOe(flashDqOe),
    .flashDqIn(flashDqIn), .flashCeN(flashCeN), .flashWeN(flashWeN), .flashOeN(flashOeN)
  );

endmodule

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;
  localparam int AW = 12, TS = 2, TP = 3, TH = 1, WD = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqOp = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [7:0]    reqData = '0;
  logic          reqReady, doneValid, flashDqOe, flashCeN, flashWeN, flashOeN;
  logic [1:0]    doneStatus;
  logic [7:0]    idData, flashDqOut;
  logic [AW-1:0] flashAddr;
  logic [7:0]    dqIn = '0;

  flash_cmd_seq #(.ADDR_W(AW), .T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH), .WD_LIMIT(WD)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqData(reqData), .reqReady(reqReady), .doneValid(doneValid), .doneStatus(doneStatus),
    .idData(idData), .flashAddr(flashAddr), .flashDqOut(flashDqOut), .flashDqOe(flashDqOe),
    .flashDqIn(dqIn), .flashCeN(flashCeN), .flashWeN(flashWeN), .flashOeN(flashOeN)
  );

  int nChk = 0, nFail = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // device model: mode 0 settles, 1 bit6 freezes, 2 bit5 then stays busy,
  // 3 bit5 then recovers, 4 never finishes
  int mode = 0, busy = 0, rdN = 0, logN = 0;
  bit idMode = 0;
  logic expB = 1'b0;
  logic [7:0] finalVal = '0, idVal = '0;
  logic [AW-1:0] wA [16];
  logic [7:0]    wD [16];

  function automatic logic [7:0] busyVal(int i, bit d5);
    return {~expB, 1'((i % 2) != 0), d5, 5'b0};
  endfunction

  function automatic logic [7:0] respond(int i);
    if (idMode) return idVal;
    case (mode)
      0: return (i < busy) ? busyVal(i, 0) : finalVal;
      1: return (i < busy) ? busyVal(i, 0) : busyVal(busy - 1, 0);
      2: return (i < busy) ? busyVal(i, 0) : busyVal(i, 1);
      3: return (i < busy) ? busyVal(i, 0) : (i == busy) ? busyVal(i, 1) : finalVal;
      default: return busyVal(i, 0);
    endcase
  endfunction

  always @(negedge flashOeN) if (!flashCeN) begin
    dqIn = respond(rdN);
    rdN++;
  end

  always @(posedge flashWeN) if (!flashCeN && logN < 16) begin
    wA[logN] = flashAddr;
    wD[logN] = flashDqOut;
    logN++;
  end

  // strobe timing monitor (R5)
  int timErr = 0, ovl = 0, ceCnt = 0, weCnt = 0, holdCnt = 0;
  bit wePrev = 1, cePrev = 1, hAct = 0;
  always @(negedge clk) if (rstN) begin
    if (!flashWeN && !flashOeN) ovl++;
    if (!flashWeN && wePrev) begin
      if (ceCnt != TS) timErr++;
      weCnt = 0;
    end
    if (flashWeN && !wePrev) begin
      if (weCnt != TP) timErr++;
      holdCnt = 0;
      hAct = 1;
    end
    if (flashCeN && !cePrev && hAct) begin
      if (holdCnt != TH) timErr++;
      hAct = 0;
    end
    if (flashCeN) ceCnt = 0; else if (flashWeN) ceCnt++;
    if (!flashWeN) weCnt++;
    if (flashWeN && !flashCeN && hAct) holdCnt++;
    wePrev = flashWeN;
    cePrev = flashCeN;
  end

  task automatic runOp(int op, int addr, int data, int m, int b, int expStatus,
                       int expReads, bit poke, string tag);
    logic [AW-1:0] eA [8];
    logic [7:0]    eD [8];
    int n = 0, bad = 0, cyc = 0;
    string seqTag;
    mode = m; busy = b; idMode = (op == 3);
    expB = (op == 0) ? data[7] : 1'b1;
    finalVal = (op == 0) ? 8'(data) : 8'hFF;
    eA[0] = 'h555; eD[0] = 8'hAA;
    eA[1] = 'h2AA; eD[1] = 8'h55;
    case (op)
      0: begin eA[2] = 'h555; eD[2] = 8'hA0; eA[3] = AW'(addr); eD[3] = 8'(data); n = 4; seqTag = "R2"; end
      3: begin eA[2] = 'h555; eD[2] = 8'h90; n = 3; seqTag = "R10"; end
      default: begin
        eA[2] = 'h555; eD[2] = 8'h80; eA[3] = 'h555; eD[3] = 8'hAA; eA[4] = 'h2AA; eD[4] = 8'h55;
        if (op == 1) begin eA[5] = AW'(addr); eD[5] = 8'h30; seqTag = "R3"; end
        else begin eA[5] = 'h555; eD[5] = 8'h10; seqTag = "R4"; end
        n = 6;
      end
    endcase
    if (expStatus != 0 || op == 3) begin eA[n] = 'h555; eD[n] = 8'hF0; n++; end
    @(negedge clk);
    logN = 0; rdN = 0; timErr = 0; ovl = 0;
    reqValid = 1; reqOp = 2'(op); reqAddr = AW'(addr); reqData = 8'(data);
    @(negedge clk);
    reqValid = 0;
    chk(!reqReady, "R11 ready low after accept", reqReady, 0);
    if (poke) begin reqValid = 1; reqOp = 2'd2; reqAddr = 'h3FF; reqData = 8'h00; end
    while (!doneValid && cyc < 3000) begin @(negedge clk); cyc++; end
    reqValid = 0;
    chk(doneValid, "R12 done seen", doneValid, 1);
    chk(doneStatus == 2'(expStatus), {tag, " status"}, doneStatus, expStatus);
    chk(rdN == expReads, {tag, " status read count"}, rdN, expReads);
    if (op == 3) chk(idData == idVal, "R10 id byte", idData, idVal);
    @(negedge clk);
    chk(!doneValid && reqReady, "R12 single pulse and R11 ready again", {doneValid, reqReady}, 1);
    for (int j = 0; j < n && j < logN; j++) if (wA[j] != eA[j] || wD[j] != eD[j]) bad++;
    chk(logN == n && bad == 0, {seqTag, " write sequence"}, logN * 256 + bad, n * 256);
    if (expStatus == 1) chk(logN == n && wD[n-1] == 8'hF0, "R8 reset write", wD[n-1], 8'hF0);
    if (expStatus == 2) chk(logN == n && wD[n-1] == 8'hF0, "R9 reset write", wD[n-1], 8'hF0);
    chk(timErr == 0, "R5 strobe timing", timErr, 0);
    chk(ovl == 0, "R5 strobe overlap", ovl, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    int addrs [5];
    int datas [5];
    addrs = '{'h000, 'hFFF, 'h555, 'h2AA, 'h9A3};
    datas = '{'h00, 'h7F, 'h80, 'hFF, 'hA5};
    repeat (3) @(negedge clk);
    chk(reqReady && !doneValid, "R1 ready/done in reset", {reqReady, doneValid}, 2);
    chk(flashCeN && flashWeN && flashOeN, "R1 strobes idle", {flashCeN, flashWeN, flashOeN}, 7);
    rstN = 1;
    @(negedge clk);
    chk(reqReady && flashCeN && flashWeN && flashOeN, "R1 after release",
        {reqReady, flashCeN, flashWeN, flashOeN}, 15);

    // R2 / R6: program sweep over addresses, payloads, busy lengths
    for (int ai = 0; ai < 5; ai++)
      for (int di = 0; di < 5; di++)
        runOp(0, addrs[ai], datas[di], 0, (ai + di) % 4, 0, (ai + di) % 4 + 1, 0, "R6 program");

    // R3 / R4 / R6: erases expect bit 7 = 1
    for (int b = 0; b < 5; b++) runOp(1, b * 'h300, 0, 0, b, 0, b + 1, 0, "R6 sector erase");
    runOp(2, 0, 0, 0, 0, 0, 1, 0, "R6 chip erase");
    runOp(2, 'h123, 0, 0, 3, 0, 4, 0, "R6 chip erase");

    // R7: bit 6 freezes while bit 7 stays wrong
    runOp(0, 'h123, 'h80, 1, 3, 0, 4, 0, "R7 toggle stop");
    runOp(0, 'h456, 'h01, 1, 1, 0, 2, 0, "R7 toggle stop");
    runOp(1, 'h400, 0, 1, 2, 0, 3, 0, "R7 toggle stop");

    // R8: bit 5 then busy, and bit 5 then recovery
    runOp(0, 'h321, 'h5A, 2, 2, 1, 4, 0, "R8 device timeout");
    runOp(2, 0, 0, 2, 0, 1, 2, 0, "R8 device timeout");
    runOp(0, 'h007, 'hC3, 3, 1, 0, 3, 0, "R8 recovery");

    // R9: never finishes
    runOp(0, 'h010, 'h01, 4, 0, 2, WD, 0, "R9 watchdog");
    runOp(1, 'h800, 0, 4, 0, 2, WD, 0, "R9 watchdog");

    // R10: identification read
    idVal = 8'h1C; runOp(3, 'h000, 0, 0, 0, 0, 1, 0, "R10 read id");
    idVal = 8'h92; runOp(3, 'h001, 0, 0, 0, 0, 1, 0, "R10 read id");

    // R11: requests while busy are ignored
    runOp(0, 'h0AA, 'h3C, 0, 2, 0, 3, 1, "R11 poke while busy");
    runOp(0, 'h0AB, 'hE1, 0, 1, 0, 2, 0, "R11 after poke");

    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule